// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver with Byte Parity

This block moves a 16-bit word with one parity bit per byte between two sides, A and B, in both directions at once. Each direction has a storage stage with three modes: it is transparent while its latch-enable is high, it captures on a clock edge when its capture strobe is high, and otherwise it holds. Each direction drives its side through a drive-enable, which models a three-state pad.

Going from A to B, the block can either build the two parity bits from the A data or pass the incoming A parity bits through and check them. Going from B to A it always passes the parity through and checks it. A single odd/even select sets the parity sense for both directions. In each direction the two byte checks are merged into one error flag. That flag is modelled as an open-drain pin: an active-low level plus a drive-enable. It is only driven while that direction's output enable is high, so it can be wired together with other flags.

The parity logic sits in front of the storage stage. The stored or passed-through word therefore carries its own check result.

Top module: `bxp_transceiver`

## Requirements
- R1: While `rst` is high at a rising clock edge, both storage stages clear to zero. With latch-enable low, both data outputs, both parity outputs and both error drive-enables then read 0.
- R2: While a direction's latch-enable is high, its data output equals its data input in the same cycle (transparent mode).
- R3: While latch-enable is low and the capture strobe is high at a rising clock edge, the direction stores its input word. That word appears on the outputs after the edge.
- R4: While latch-enable and capture strobe are both low, a direction's outputs do not change when its inputs change.
- R5: With `ab_gen` = 1, B parity bit i equals the XOR of A byte i XOR `odd_sel`. Byte i is bits [8i+7:8i], and `odd_sel` = 1 selects odd parity.
- R6: With `ab_gen` = 0, the B parity outputs carry the A parity inputs. The A-to-B error is set when, for any byte i, (XOR of byte i) XOR parity bit i differs from `odd_sel`.
- R7: The B-to-A direction always passes `b_par_i` to `a_par_o` and flags a mismatch with the same rule as R6.
- R8: In generate mode (`ab_gen` = 1), the A-to-B error flag is never driven, whatever the A parity inputs are.
- R9: A direction's error drive-enable is high only when its stored or transparent error is set and its output enable is high. The active-low flag output is 0 exactly when that drive-enable is 1.
- R10: A direction's data/parity drive-enable equals its output-enable input.
- R11: The controls and inputs of one direction have no effect on the outputs of the other direction.
- R12: The parity check result is formed at the input of the storage stage. A captured error flag stays fixed while `odd_sel` or the inputs change in hold mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | Parity sense for both directions, 1 = odd |
| ab_gen | input | 1 | A-to-B mode: 1 = generate parity, 0 = check |
| ab_le | input | 1 | A-to-B latch-enable (transparent when high) |
| ab_cap | input | 1 | A-to-B capture strobe, sampled at the clock edge |
| ab_oe | input | 1 | A-to-B output enable |
| a_data_i | input | DATA_W | A-side data in |
| a_par_i | input | DATA_W/BYTE_W | A-side parity in, bit i for byte i |
| b_data_o | output | DATA_W | B-side data out |
| b_par_o | output | DATA_W/BYTE_W | B-side parity out |
| b_drv_o | output | 1 | B-side pad drive-enable |
| ab_err_n_o | output | 1 | A-to-B error flag, active low |
| ab_err_drv_o | output | 1 | A-to-B error flag pull-down enable |
| ba_le | input | 1 | B-to-A latch-enable |
| ba_cap | input | 1 | B-to-A capture strobe |
| ba_oe | input | 1 | B-to-A output enable |
| b_data_i | input | DATA_W | B-side data in |
| b_par_i | input | DATA_W/BYTE_W | B-side parity in |
| a_data_o | output | DATA_W | A-side data out |
| a_par_o | output | DATA_W/BYTE_W | A-side parity out |
| a_drv_o | output | 1 | A-side pad drive-enable |
| ba_err_n_o | output | 1 | B-to-A error flag, active low |
| ba_err_drv_o | output | 1 | B-to-A error flag pull-down enable |

## Verification
The assertions check on every cycle:
- flag gating and drive-enables follow the output enables;
- transparent data matches the inputs;
- a held stage stays stable and a captured word appears one edge later;
- generated parity matches the data, and the A-to-B flag stays quiet in generate mode.

Only the directed scenarios show the following: the parity sense flips with `odd_sel`, single-byte corruption is detected in each direction, a captured error outlives later input or sense changes, and one direction is isolated from the other's controls.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_BYTE_W = 8;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } sense_e;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_GEN   = 1'b1
    } par_mode_e;

    // parity bit that completes a byte to the requested sense
    function automatic logic fill_bit(input logic data_xor, input sense_e sense);
        return data_xor ^ (sense == SENSE_ODD);
    endfunction

endpackage

// File: rtl/bxp_lane_par.sv
module bxp_lane_par
    import bxp_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              par_i,
    input  logic              odd_i,
    input  logic              gen_i,
    output logic              par_o,
    output logic              err_o
);
    sense_e    sense;
    par_mode_e mode;
    logic      calc;

    always_comb begin
        sense = odd_i ? SENSE_ODD : SENSE_EVEN;
        mode  = gen_i ? MODE_GEN : MODE_CHECK;
        calc  = fill_bit(^byte_i, sense);
        if (mode == MODE_GEN) begin
            par_o = calc;
            err_o = 1'b0;
        end else begin
            par_o = par_i;
            err_o = (calc != par_i);
        end
    end
endmodule

// File: rtl/bxp_hold.sv
module bxp_hold #(
    parameter int unsigned W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (le || cap) begin
            held <= d;
        end
    end

    assign q = le ? d : held;
endmodule

// File: rtl/bxp_path.sv
module bxp_path
    import bxp_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned BYTE_W  = DEF_BYTE_W,
    parameter bit          CAN_GEN = 1'b1,
    localparam int unsigned LANES  = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              odd_sel,
    input  logic              gen_sel,
    input  logic              le,
    input  logic              cap,
    input  logic              oe,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LANES-1:0]  par_i,
    output logic [DATA_W-1:0] data_o,
    output logic [LANES-1:0]  par_o,
    output logic              drv_o,
    output logic              err_n_o,
    output logic              err_drv_o
);
    typedef struct packed {
        logic              err;
        logic [LANES-1:0]  par;
        logic [DATA_W-1:0] data;
    } word_t;

    localparam int unsigned WORD_W = $bits(word_t);

    logic             gen_eff;
    logic [LANES-1:0] par_nx;
    logic [LANES-1:0] lane_err;
    word_t            nx_word;
    word_t            cur_word;

    assign gen_eff = gen_sel & CAN_GEN;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bxp_lane_par #(.BYTE_W(BYTE_W)) u_lane (
            .byte_i (data_i[g*BYTE_W +: BYTE_W]),
            .par_i  (par_i[g]),
            .odd_i  (odd_sel),
            .gen_i  (gen_eff),
            .par_o  (par_nx[g]),
            .err_o  (lane_err[g])
        );
    end

    always_comb begin
        nx_word.err  = |lane_err;
        nx_word.par  = par_nx;
        nx_word.data = data_i;
    end

    bxp_hold #(.W(WORD_W)) u_hold (
        .clk (clk),
        .rst (rst),
        .le  (le),
        .cap (cap),
        .d   (nx_word),
        .q   (cur_word)
    );

    assign data_o    = cur_word.data;
    assign par_o     = cur_word.par;
    assign drv_o     = oe;
    assign err_drv_o = cur_word.err & oe;
    assign err_n_o   = ~(cur_word.err & oe);
endmodule

// File: rtl/bxp_transceiver.sv
module bxp_transceiver
    import bxp_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned LANES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              odd_sel,
    input  logic              ab_gen,
    input  logic              ab_le,
    input  logic              ab_cap,
    input  logic              ab_oe,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic [LANES-1:0]  a_par_i,
    output logic [DATA_W-1:0] b_data_o,
    output logic [LANES-1:0]  b_par_o,
    output logic              b_drv_o,
    output logic              ab_err_n_o,
    output logic              ab_err_drv_o,
    input  logic              ba_le,
    input  logic              ba_cap,
    input  logic              ba_oe,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic [LANES-1:0]  b_par_i,
    output logic [DATA_W-1:0] a_data_o,
    output logic [LANES-1:0]  a_par_o,
    output logic              a_drv_o,
    output logic              ba_err_n_o,
    output logic              ba_err_drv_o
);
    bxp_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CAN_GEN(1'b1)) u_ab (
        .clk       (clk),
        .rst       (rst),
        .odd_sel   (odd_sel),
        .gen_sel   (ab_gen),
        .le        (ab_le),
        .cap       (ab_cap),
        .oe        (ab_oe),
        .data_i    (a_data_i),
        .par_i     (a_par_i),
        .data_o    (b_data_o),
        .par_o     (b_par_o),
        .drv_o     (b_drv_o),
        .err_n_o   (ab_err_n_o),
        .err_drv_o (ab_err_drv_o)
    );

    bxp_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CAN_GEN(1'b0)) u_ba (
        .clk       (clk),
        .rst       (rst),
        .odd_sel   (odd_sel),
        .gen_sel   (1'b0),
        .le        (ba_le),
        .cap       (ba_cap),
        .oe        (ba_oe),
        .data_i    (b_data_i),
        .par_i     (b_par_i),
        .data_o    (a_data_o),
        .par_o     (a_par_o),
        .drv_o     (a_drv_o),
        .err_n_o   (ba_err_n_o),
        .err_drv_o (ba_err_drv_o)
    );
endmodule

// File: rtl/bxp_checker.sv
module bxp_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned LANES = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              odd_sel,
    input logic              ab_gen,
    input logic              ab_le,
    input logic              ab_cap,
    input logic              ab_oe,
    input logic [DATA_W-1:0] a_data_i,
    input logic [DATA_W-1:0] b_data_o,
    input logic [LANES-1:0]  b_par_o,
    input logic              b_drv_o,
    input logic              ab_err_n_o,
    input logic              ab_err_drv_o,
    input logic              ba_le,
    input logic              ba_cap,
    input logic              ba_oe,
    input logic [DATA_W-1:0] b_data_i,
    input logic [LANES-1:0]  b_par_i,
    input logic [DATA_W-1:0] a_data_o,
    input logic [LANES-1:0]  a_par_o,
    input logic              a_drv_o,
    input logic              ba_err_n_o,
    input logic              ba_err_drv_o
);
    function automatic logic [LANES-1:0] ref_par(input logic [DATA_W-1:0] d, input logic odd);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i] = (^d[i*BYTE_W +: BYTE_W]) ^ odd;
        end
        return r;
    endfunction

    p_transp_ab_r2: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> b_data_o == a_data_i);
    p_transp_ba_r2: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> a_data_o == b_data_i);
    p_capture_ab_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && $past(!ab_le && ab_cap)) |-> b_data_o == $past(a_data_i));
    p_hold_ab_r4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && $past(!ab_le && !ab_cap)) |-> ($stable(b_data_o) && $stable(b_par_o)));
    p_hold_ba_r4: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && $past(!ba_le && !ba_cap)) |-> ($stable(a_data_o) && $stable(a_par_o)));
    p_gen_par_r5: assert property (@(posedge clk) disable iff (rst)
        (ab_le && ab_gen) |-> b_par_o == ref_par(a_data_i, odd_sel));
    p_pass_par_r7: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> a_par_o == b_par_i);
    p_gen_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ab_le && ab_gen) |-> !ab_err_drv_o);
    p_flag_gate_ab_r9: assert property (@(posedge clk) disable iff (rst)
        !ab_oe |-> (!ab_err_drv_o && ab_err_n_o));
    p_flag_gate_ba_r9: assert property (@(posedge clk) disable iff (rst)
        !ba_oe |-> (!ba_err_drv_o && ba_err_n_o));
    p_flag_level_r9: assert property (@(posedge clk) disable iff (rst)
        (ab_err_n_o != ab_err_drv_o) && (ba_err_n_o != ba_err_drv_o));
    p_drive_r10: assert property (@(posedge clk) disable iff (rst)
        (b_drv_o == ab_oe) && (a_drv_o == ba_oe));
endmodule

bind bxp_transceiver bxp_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .odd_sel      (odd_sel),
    .ab_gen       (ab_gen),
    .ab_le        (ab_le),
    .ab_cap       (ab_cap),
    .ab_oe        (ab_oe),
    .a_data_i     (a_data_i),
    .b_data_o     (b_data_o),
    .b_par_o      (b_par_o),
    .b_drv_o      (b_drv_o),
    .ab_err_n_o   (ab_err_n_o),
    .ab_err_drv_o (ab_err_drv_o),
    .ba_le        (ba_le),
    .ba_cap       (ba_cap),
    .ba_oe        (ba_oe),
    .b_data_i     (b_data_i),
    .b_par_i      (b_par_i),
    .a_data_o     (a_data_o),
    .a_par_o      (a_par_o),
    .a_drv_o      (a_drv_o),
    .ba_err_n_o   (ba_err_n_o),
    .ba_err_drv_o (ba_err_drv_o)
);

// File: tb/sim_bxp_transceiver.sv
module sim_bxp_transceiver;
    logic        clk = 1'b0;
    logic        rst;
    logic        odd_sel, ab_gen, ab_le, ab_cap, ab_oe;
    logic [15:0] a_data_i;
    logic [1:0]  a_par_i;
    logic [15:0] b_data_o;
    logic [1:0]  b_par_o;
    logic        b_drv_o, ab_err_n_o, ab_err_drv_o;
    logic        ba_le, ba_cap, ba_oe;
    logic [15:0] b_data_i;
    logic [1:0]  b_par_i;
    logic [15:0] a_data_o;
    logic [1:0]  a_par_o;
    logic        a_drv_o, ba_err_n_o, ba_err_drv_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bxp_transceiver u0 (.*);

    function automatic logic [1:0] gp(input logic [15:0] d, input logic odd);
        return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; odd_sel = 1'b0; ab_gen = 1'b0; ab_le = 1'b0; ab_cap = 1'b0; ab_oe = 1'b1;
        ba_le = 1'b0; ba_cap = 1'b0; ba_oe = 1'b1;
        a_data_i = 16'hFFFF; a_par_i = 2'b01; b_data_i = 16'hFFFF; b_par_i = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 b_data", 32'(b_data_o), 32'h0);
        chk("R1 a_data", 32'(a_data_o), 32'h0);
        chk("R1 pars", 32'({b_par_o, a_par_o}), 32'h0);
        chk("R1 err drives", 32'({ab_err_drv_o, ba_err_drv_o}), 32'h0);
    endtask

    task automatic t_transparent;
        @(negedge clk);
        ab_le = 1'b1; ab_oe = 1'b1; ab_gen = 1'b0; odd_sel = 1'b0;
        a_data_i = 16'h1234; a_par_i = gp(16'h1234, 1'b0); #1;
        chk("R2 transparent data", 32'(b_data_o), 32'h1234);
        chk("R10 drive on", 32'(b_drv_o), 32'h1);
        a_data_i = 16'hA5C3; a_par_i = gp(16'hA5C3, 1'b0); #1;
        chk("R2 transparent follows", 32'(b_data_o), 32'hA5C3);
        ab_oe = 1'b0; #1;
        chk("R10 drive off", 32'(b_drv_o), 32'h0);
        ab_oe = 1'b1;
    endtask

    task automatic t_capture_hold;
        @(negedge clk);
        ab_le = 1'b0; ab_cap = 1'b1; a_data_i = 16'h5A0F; a_par_i = gp(16'h5A0F, 1'b0);
        @(negedge clk);
        ab_cap = 1'b0; #1;
        chk("R3 captured", 32'(b_data_o), 32'h5A0F);
        a_data_i = 16'h0F0F; a_par_i = 2'b00;
        repeat (2) @(negedge clk); #1;
        chk("R4 held data", 32'(b_data_o), 32'h5A0F);
        chk("R4 held par", 32'(b_par_o), 32'(gp(16'h5A0F, 1'b0)));
    endtask

    task automatic t_generate;
        @(negedge clk);
        ab_le = 1'b1; ab_gen = 1'b1; ab_oe = 1'b1;
        a_data_i = 16'h0107; a_par_i = ~gp(16'h0107, 1'b0);
        for (int s = 0; s < 2; s++) begin
            odd_sel = s[0]; #1;
            chk("R5 generated parity", 32'(b_par_o), 32'(gp(16'h0107, s[0])));
            chk("R8 gen flag quiet", 32'({ab_err_drv_o, ab_err_n_o}), 32'h1);
        end
        ab_gen = 1'b0; odd_sel = 1'b0;
    endtask

    task automatic t_check_ab;
        @(negedge clk);
        ab_le = 1'b1; ab_gen = 1'b0; ab_oe = 1'b1; odd_sel = 1'b0;
        a_data_i = 16'h3C81; a_par_i = gp(16'h3C81, 1'b0); #1;
        chk("R6 pass parity", 32'(b_par_o), 32'(gp(16'h3C81, 1'b0)));
        chk("R6 good no flag", 32'({ab_err_drv_o, ab_err_n_o}), 32'h1);
        a_par_i = gp(16'h3C81, 1'b0) ^ 2'b10; #1;
        chk("R6 byte1 error", 32'({ab_err_drv_o, ab_err_n_o}), 32'h2);
        a_par_i = gp(16'h3C81, 1'b0) ^ 2'b01; #1;
        chk("R6 byte0 error", 32'(ab_err_drv_o), 32'h1);
        ab_oe = 1'b0; #1;
        chk("R9 gated by oe", 32'({ab_err_drv_o, ab_err_n_o}), 32'h1);
        ab_oe = 1'b1; a_par_i = gp(16'h3C81, 1'b0); odd_sel = 1'b1; #1;
        chk("R6 sense flip", 32'(ab_err_drv_o), 32'h1);
        odd_sel = 1'b0;
    endtask

    task automatic t_check_ba;
        @(negedge clk);
        ba_le = 1'b1; ba_oe = 1'b1; odd_sel = 1'b1;
        b_data_i = 16'hE2D4; b_par_i = gp(16'hE2D4, 1'b1); #1;
        chk("R7 ba data", 32'(a_data_o), 32'hE2D4);
        chk("R7 ba parity", 32'(a_par_o), 32'(gp(16'hE2D4, 1'b1)));
        chk("R7 ba good", 32'(ba_err_drv_o), 32'h0);
        b_par_i = gp(16'hE2D4, 1'b1) ^ 2'b01; #1;
        chk("R7 ba error", 32'({ba_err_drv_o, ba_err_n_o}), 32'h2);
        ba_oe = 1'b0; #1;
        chk("R9 ba gated", 32'(ba_err_drv_o), 32'h0);
        ba_oe = 1'b1; odd_sel = 1'b0;
    endtask

    task automatic t_frozen_flag;
        @(negedge clk);
        ab_le = 1'b0; ab_cap = 1'b1; ab_gen = 1'b0; ab_oe = 1'b1; odd_sel = 1'b0;
        a_data_i = 16'h0001; a_par_i = 2'b00;
        @(negedge clk);
        ab_cap = 1'b0; #1;
        chk("R12 captured error", 32'(ab_err_drv_o), 32'h1);
        odd_sel = 1'b1; a_par_i = 2'b11; a_data_i = 16'h0000;
        repeat (2) @(negedge clk); #1;
        chk("R12 error frozen", 32'(ab_err_drv_o), 32'h1);
        odd_sel = 1'b0;
    endtask

    task automatic t_independent;
        logic [15:0] snap_d;
        logic [1:0]  snap_p;
        @(negedge clk);
        ab_le = 1'b0; ab_cap = 1'b0; #1;
        snap_d = b_data_o; snap_p = b_par_o;
        ba_le = 1'b1; ba_oe = 1'b0; b_data_i = 16'h7777; b_par_i = 2'b10;
        @(negedge clk);
        ba_le = 1'b0; ba_cap = 1'b1; b_data_i = 16'h9999;
        @(negedge clk); ba_cap = 1'b0; #1;
        chk("R11 b side unchanged", 32'({b_par_o, b_data_o}), 32'({snap_p, snap_d}));
        chk("R11 ab flag unchanged", 32'(ab_err_drv_o), 32'h1);
        chk("R11 b drive unchanged", 32'(b_drv_o), 32'h1);
        chk("R3 ba captured", 32'(a_data_o), 32'h9999);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_capture_hold();
        t_generate();
        t_check_ab();
        t_check_ba();
        t_frozen_flag();
        t_independent();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule